// File: doc/BRIEF.md
# Shared-Memory Windowed Transmit/Receive FIFO

This block keeps one buffer memory of 2^ADDR_W data words (64 by default) and carves two FIFOs out of it at run time. A transmit FIFO takes words pushed by software and offers them to a serial transmitter through a valid/ready handshake. A receive FIFO takes words from a receiver and hands them to software pops. Each FIFO is a window in the shared memory. The window is set by a base entry and a 3-bit size code that selects a power-of-two length. The physical entry of a slot is the base plus its offset in the window, taken modulo the memory depth. Software can place the two windows anywhere, and must keep them from overlapping.

A base write is taken only while that FIFO is disabled (size code zero). Software therefore sets the base first and then the size. Every size write and every flush empties the FIFO and clears its sticky overflow and underflow flags. A small state machine guards the transmit output. In TXG_RUN, words flow whenever the FIFO holds data and no protocol fault is present. When the protocol engine raises a NACK or an error, the machine moves TXG_RUN to TXG_HALT. When the fault inputs fall, it moves TXG_HALT to TXG_ARMED. A transmit flush then moves either TXG_HALT (fault already gone) or TXG_ARMED back to TXG_RUN. A fault seen while in TXG_ARMED returns the machine to TXG_HALT.

Top module: `winbuf_fifo`

## Requirements
- R1: Size code 001 to 110 gives a window of 2, 4, 8, 16, 32 or 64 entries. Code 000 and the reserved code 111 disable the FIFO. A disabled FIFO holds nothing, and reading back the size register returns the code last written.
- R2: A disabled FIFO refuses every push and pop. Its level stays 0, tx_valid and rx_avail stay low, and no sticky flag is set.
- R3: A base write (cfg_addr 0 for transmit, 2 for receive) made while the size code is 000 moves both pointers to that entry and leaves the FIFO empty. Slot k of the window lives at physical entry base+k modulo the depth.
- R4: A base write made while the FIFO is enabled is ignored. The stored words, their order and the level are unchanged.
- R5: Reading a base register returns 0. The size registers are cfg_addr 1 (transmit) and 3 (receive), and their code appears in cfg_rdata[2:0].
- R6: Words leave in push order. The pointers wrap inside the window, so traffic in one window never disturbs words held in a disjoint window.
- R7: A push to a full FIFO is dropped and sets the sticky overflow flag. A pop from an empty FIFO is dropped and sets the sticky underflow flag.
- R8: A push and a pop in the same cycle on a FIFO that is neither empty nor full both complete, and the level is unchanged.
- R9: A flush empties its FIFO within one cycle, drops any push made in that cycle, and clears that FIFO's sticky flags.
- R10: tx_valid is high with the oldest word on tx_data when the transmit FIFO holds data and the guard is in TXG_RUN with no fault input high. A cycle with tx_valid and tx_ready removes that word.
- R11: A high proto_nack or proto_err drops tx_valid in the same cycle and halts the transmit side (tx_halted high). Sending resumes only after both fault inputs are low and a transmit flush has been seen.
- R12: A size write empties the FIFO, even when the new code equals the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 transmit base, 1 transmit size, 2 receive base, 3 receive size |
| cfg_wdata | input | ADDR_W | Write data (size code in bits 2:0) |
| cfg_rdata | output | ADDR_W | Read data for cfg_addr; base reads return 0 |
| tx_flush | input | 1 | Empty the transmit FIFO |
| rx_flush | input | 1 | Empty the receive FIFO |
| sw_push | input | 1 | Software push into the transmit FIFO |
| sw_push_data | input | DATA_W | Word to push |
| tx_valid | output | 1 | Word offered to the transmitter |
| tx_data | output | DATA_W | Oldest transmit word (0 when not valid) |
| tx_ready | input | 1 | Transmitter accepts the offered word |
| rx_push | input | 1 | Receiver push into the receive FIFO |
| rx_push_data | input | DATA_W | Received word |
| sw_pop | input | 1 | Software pop from the receive FIFO |
| sw_pop_data | output | DATA_W | Oldest receive word (0 when empty) |
| rx_avail | output | 1 | Receive FIFO holds data |
| proto_nack | input | 1 | Protocol engine reports NACK |
| proto_err | input | 1 | Protocol engine reports an error |
| tx_halted | output | 1 | Transmit guard not in TXG_RUN |
| tx_level | output | ADDR_W+1 | Transmit fill level |
| rx_level | output | ADDR_W+1 | Receive fill level |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
A wrong base or offset register shows up as wrong data. It appears on tx_data or sw_pop_data as soon as the slot concerned reaches the head. With two overlapping windows, a wrong write address shows on the other FIFO's head in the cycle right after the push. A wrong fill counter shows on the level outputs in the next cycle, and at a boundary it also sets a sticky flag that should have stayed clear. A guard stuck in the wrong state shows on tx_valid and tx_halted in the same cycle, while words wait in the FIFO.

// File: rtl/winbuf_pkg.sv
package winbuf_pkg;
    typedef enum logic [1:0] {
        TXG_RUN   = 2'd0,
        TXG_HALT  = 2'd1,
        TXG_ARMED = 2'd2
    } txg_state_e;

    localparam logic [1:0] CFG_TX_BASE = 2'd0;
    localparam logic [1:0] CFG_TX_SIZE = 2'd1;
    localparam logic [1:0] CFG_RX_BASE = 2'd2;
    localparam logic [1:0] CFG_RX_SIZE = 2'd3;

    localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/winbuf_ram.sv
module winbuf_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [ADDR_W-1:0] a_raddr,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port b is written last, so it wins on a shared entry.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_waddr] <= a_wdata;
        if (b_we) mem[b_waddr] <= b_wdata;
    end

    assign a_rdata = mem[a_raddr];
    assign b_rdata = mem[b_raddr];
endmodule

// File: rtl/winbuf_win.sv
module winbuf_win #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              size_we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   level,
    output logic              enabled,
    output logic [2:0]        code,
    output logic              push_fire,
    output logic              pop_fire,
    output logic              ovf,
    output logic              unf
);
    localparam int CNT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] base_q, in_q, out_q, mask;
    logic [CNT_W-1:0]  len, cnt_q;
    logic              full, empty, hold;

    always_comb begin
        len = '0;
        if (code != 3'd0 && int'(code) <= ADDR_W)
            len = CNT_W'(1) << code;
    end

    assign enabled   = (len != '0);
    assign mask      = len[ADDR_W-1:0] - ADDR_W'(1);
    assign full      = enabled && (cnt_q == len);
    assign empty     = (cnt_q == '0);
    assign hold      = flush || size_we;
    assign push_fire = enabled && push && !full && !hold;
    assign pop_fire  = enabled && pop && !empty && !hold;
    assign wr_addr   = base_q + in_q;
    assign rd_addr   = base_q + out_q;
    assign level     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code   <= '0;
            base_q <= '0;
            in_q   <= '0;
            out_q  <= '0;
            cnt_q  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else if (size_we) begin
            code  <= wdata[2:0];
            in_q  <= '0;
            out_q <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else if (flush) begin
            in_q  <= '0;
            out_q <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (ptr_we && !enabled) begin
                base_q <= wdata;
                in_q   <= '0;
                out_q  <= '0;
                cnt_q  <= '0;
            end
            if (push_fire) in_q  <= (in_q + ADDR_W'(1)) & mask;
            if (pop_fire)  out_q <= (out_q + ADDR_W'(1)) & mask;
            if (push_fire && !pop_fire)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop_fire && !push_fire) cnt_q <= cnt_q - CNT_W'(1);
            if (enabled && push && full)  ovf <= 1'b1;
            if (enabled && pop && empty)  unf <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len); // R7
    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (cnt_q == '0)); // R2
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && enabled && !size_we) |=> (base_q == $past(base_q))); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0) && !ovf && !unf); // R9
    AST_SIZE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        size_we |=> (cnt_q == '0)); // R12
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && pop_fire) |=> $stable(cnt_q)); // R8
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> (CNT_W'(ADDR_W'(wr_addr - base_q)) < len)); // R6
endmodule

// File: rtl/winbuf_txgate.sv
module winbuf_txgate
    import winbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic flush,
    output logic send_ok,
    output logic halted
);
    txg_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TXG_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXG_RUN:   if (fault) st_d = TXG_HALT;
            TXG_HALT:  if (!fault) st_d = flush ? TXG_RUN : TXG_ARMED;
            TXG_ARMED: if (fault) st_d = TXG_HALT;
                       else if (flush) st_d = TXG_RUN;
            default:   st_d = TXG_HALT;
        endcase
    end

    always_comb begin
        send_ok = (st_q == TXG_RUN) && !fault;
        halted  = (st_q != TXG_RUN);
    end

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (st_q == TXG_HALT)); // R11
    AST_HALT_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TXG_RUN && !flush) |=> (st_q != TXG_RUN)); // R11
endmodule

// File: rtl/winbuf_fifo.sv
module winbuf_fifo
    import winbuf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic              sw_push,
    input  logic [DATA_W-1:0] sw_push_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              sw_pop,
    output logic [DATA_W-1:0] sw_pop_data,
    output logic              rx_avail,
    input  logic              proto_nack,
    input  logic              proto_err,
    output logic              tx_halted,
    output logic [ADDR_W:0]   tx_level,
    output logic [ADDR_W:0]   rx_level,
    output logic              tx_ovf,
    output logic              tx_unf,
    output logic              rx_ovf,
    output logic              rx_unf
);
    logic [ADDR_W-1:0] tx_wa, tx_ra, rx_wa, rx_ra;
    logic [2:0]        tx_code, rx_code;
    logic              tx_en, rx_en, tx_wfire, rx_wfire;
    logic              tx_rfire, rx_rfire;
    logic              send_ok, tx_pop;
    logic [DATA_W-1:0] tx_head, rx_head;

    assign tx_pop = tx_valid && tx_ready;

    winbuf_win #(.ADDR_W(ADDR_W)) u_txwin (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(cfg_we && cfg_addr == CFG_TX_BASE),
        .size_we(cfg_we && cfg_addr == CFG_TX_SIZE),
        .wdata(cfg_wdata), .flush(tx_flush),
        .push(sw_push), .pop(tx_pop),
        .wr_addr(tx_wa), .rd_addr(tx_ra), .level(tx_level),
        .enabled(tx_en), .code(tx_code),
        .push_fire(tx_wfire), .pop_fire(tx_rfire),
        .ovf(tx_ovf), .unf(tx_unf)
    );

    winbuf_win #(.ADDR_W(ADDR_W)) u_rxwin (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(cfg_we && cfg_addr == CFG_RX_BASE),
        .size_we(cfg_we && cfg_addr == CFG_RX_SIZE),
        .wdata(cfg_wdata), .flush(rx_flush),
        .push(rx_push), .pop(sw_pop),
        .wr_addr(rx_wa), .rd_addr(rx_ra), .level(rx_level),
        .enabled(rx_en), .code(rx_code),
        .push_fire(rx_wfire), .pop_fire(rx_rfire),
        .ovf(rx_ovf), .unf(rx_unf)
    );

    winbuf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk),
        .a_we(tx_wfire), .a_waddr(tx_wa), .a_wdata(sw_push_data),
        .b_we(rx_wfire), .b_waddr(rx_wa), .b_wdata(rx_push_data),
        .a_raddr(tx_ra), .a_rdata(tx_head),
        .b_raddr(rx_ra), .b_rdata(rx_head)
    );

    winbuf_txgate u_gate (
        .clk(clk), .rst_n(rst_n),
        .fault(proto_nack || proto_err),
        .flush(tx_flush),
        .send_ok(send_ok), .halted(tx_halted)
    );

    always_comb begin
        tx_valid    = send_ok && tx_en && (tx_level != '0);
        tx_data     = tx_valid ? tx_head : '0;
        rx_avail    = rx_en && (rx_level != '0);
        sw_pop_data = rx_avail ? rx_head : '0;
        unique case (cfg_addr)
            CFG_TX_SIZE: cfg_rdata = ADDR_W'(tx_code);
            CFG_RX_SIZE: cfg_rdata = ADDR_W'(rx_code);
            default:     cfg_rdata = '0;
        endcase
    end

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halted |-> !tx_valid); // R11
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_nack || proto_err) |-> !tx_valid); // R11
    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_level != '0)); // R10
    AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !sw_push && !tx_flush && !(cfg_we && cfg_addr == CFG_TX_SIZE))
        |=> (tx_level == $past(tx_level) - 1'b1)); // R10
    AST_DISABLED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !rx_avail && !rx_rfire); // R2
endmodule

// File: tb/winbuf_fifo_tb.sv
module winbuf_fifo_tb;
    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
    logic tx_flush = 1'b0, rx_flush = 1'b0;
    logic sw_push = 1'b0;
    logic [DW-1:0] sw_push_data = '0;
    logic tx_valid;
    logic [DW-1:0] tx_data;
    logic tx_ready = 1'b0;
    logic rx_push = 1'b0;
    logic [DW-1:0] rx_push_data = '0;
    logic sw_pop = 1'b0;
    logic [DW-1:0] sw_pop_data;
    logic rx_avail;
    logic proto_nack = 1'b0, proto_err = 1'b0;
    logic tx_halted;
    logic [AW:0] tx_level, rx_level;
    logic tx_ovf, tx_unf, rx_ovf, rx_unf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    winbuf_fifo #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_flush(tx_flush), .rx_flush(rx_flush),
        .sw_push(sw_push), .sw_push_data(sw_push_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .sw_pop(sw_pop), .sw_pop_data(sw_pop_data), .rx_avail(rx_avail),
        .proto_nack(proto_nack), .proto_err(proto_err), .tx_halted(tx_halted),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // side 0 = transmit, 1 = receive
    task automatic setup(input bit side, input logic [AW-1:0] base, input logic [2:0] code);
        cfg_wr(side ? 2'd3 : 2'd1, '0);
        cfg_wr(side ? 2'd2 : 2'd0, base);
        cfg_wr(side ? 2'd3 : 2'd1, AW'(code));
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        sw_push = 1'b1; sw_push_data = d;
        tick();
        sw_push = 1'b0;
    endtask

    task automatic push_rx(input logic [DW-1:0] d);
        rx_push = 1'b1; rx_push_data = d;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        sw_pop = 1'b1;
        tick();
        sw_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 reset tx_level", tx_level, 0);
        chk("R2 reset rx_level", rx_level, 0);
        chk("R2 reset tx_valid", tx_valid, 0);
        chk("R2 reset rx_avail", rx_avail, 0);
        chk("R11 reset tx_halted", tx_halted, 0);
    endtask

    task automatic t_size_map();
        tx_ready = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            setup(0, '0, 3'(c));
            cfg_addr = 2'd1; #1;
            chk("R1 size readback", cfg_rdata, c);
            for (int k = 0; k <= (1 << c); k++) push_tx(DW'(k + 1));
            chk("R1 window length", tx_level, 1 << c);
            chk("R7 overflow sticky", tx_ovf, 1);
        end
        setup(0, '0, 3'd7);
        push_tx(16'h0777);
        chk("R1 reserved code disabled", tx_level, 0);
        chk("R1 reserved code no valid", tx_valid, 0);
        cfg_wr(2'd0, 6'd5);
        cfg_addr = 2'd0; #1;
        chk("R5 base reads zero", cfg_rdata, 0);
    endtask

    task automatic t_disabled();
        setup(0, 6'd16, 3'd0);
        setup(1, 6'd24, 3'd0);
        push_tx(16'h1111);
        push_rx(16'h2222);
        pop_rx();
        chk("R2 tx level stays 0", tx_level, 0);
        chk("R2 rx level stays 0", rx_level, 0);
        chk("R2 no tx_valid", tx_valid, 0);
        chk("R2 no rx_avail", rx_avail, 0);
        chk("R2 no underflow flag", rx_unf, 0);
        chk("R2 no overflow flag", tx_ovf, 0);
    endtask

    task automatic t_ptr_ignore();
        tx_ready = 1'b0;
        setup(0, 6'd16, 3'd3);
        push_tx(16'hA0A0);
        push_tx(16'hB1B1);
        cfg_wr(2'd0, 6'd40);
        chk("R4 level unchanged", tx_level, 2);
        chk("R4 head unchanged", tx_data, 16'hA0A0);
        tx_ready = 1'b1;
        tick();
        chk("R4 second word", tx_data, 16'hB1B1);
        tick();
        tx_ready = 1'b0;
        chk("R10 drained", tx_level, 0);
    endtask

    task automatic t_window();
        tx_ready = 1'b0;
        setup(0, 6'd16, 3'd1);
        setup(1, 6'd17, 3'd1);
        push_rx(16'h5A5A);
        chk("R3 rx head before", sw_pop_data, 16'h5A5A);
        push_tx(16'hC000);
        push_tx(16'hC001);
        chk("R3 shared entry base+offset", sw_pop_data, 16'hC001);
        // disjoint windows, wrap test
        setup(0, 6'd16, 3'd3);
        setup(1, 6'd24, 3'd3);
        for (int k = 0; k < 5; k++) push_rx(DW'(16'h3000 + k));
        for (int k = 0; k < 20; k++) begin
            push_tx(DW'(16'h4000 + k));
            chk("R6 tx order", tx_data, 16'h4000 + k);
            tx_ready = 1'b1;
            tick();
            tx_ready = 1'b0;
        end
        chk("R6 tx empty", tx_level, 0);
        for (int k = 0; k < 5; k++) begin
            chk("R6 rx intact", sw_pop_data, 16'h3000 + k);
            pop_rx();
        end
    endtask

    task automatic t_full_empty();
        setup(1, 6'd30, 3'd1);
        push_rx(16'h0101);
        push_rx(16'h0202);
        push_rx(16'h0303);
        chk("R7 full level", rx_level, 2);
        chk("R7 rx overflow", rx_ovf, 1);
        chk("R7 first word kept", sw_pop_data, 16'h0101);
        pop_rx();
        chk("R7 second word kept", sw_pop_data, 16'h0202);
        pop_rx();
        chk("R7 no underflow yet", rx_unf, 0);
        pop_rx();
        chk("R7 rx underflow", rx_unf, 1);
        chk("R7 level zero", rx_level, 0);
        rx_flush = 1'b1; tick(); rx_flush = 1'b0;
        chk("R9 flags cleared ovf", rx_ovf, 0);
        chk("R9 flags cleared unf", rx_unf, 0);
    endtask

    task automatic t_simul();
        setup(1, 6'd40, 3'd2);
        push_rx(16'hD000);
        push_rx(16'hD001);
        rx_push = 1'b1; rx_push_data = 16'hD002; sw_pop = 1'b1;
        tick();
        rx_push = 1'b0; sw_pop = 1'b0;
        chk("R8 level unchanged", rx_level, 2);
        chk("R8 head advanced", sw_pop_data, 16'hD001);
        pop_rx();
        chk("R8 pushed word kept", sw_pop_data, 16'hD002);
        push_rx(16'hD003);
        cfg_wr(2'd3, 6'd2);
        chk("R12 size write empties", rx_level, 0);
        chk("R12 no rx_avail", rx_avail, 0);
    endtask

    task automatic t_flush();
        tx_ready = 1'b0;
        setup(0, 6'd16, 3'd3);
        push_tx(16'hE0);
        push_tx(16'hE1);
        push_tx(16'hE2);
        tx_flush = 1'b1; sw_push = 1'b1; sw_push_data = 16'hEE;
        tick();
        tx_flush = 1'b0; sw_push = 1'b0;
        chk("R9 tx flushed", tx_level, 0);
        chk("R9 no valid after flush", tx_valid, 0);
    endtask

    task automatic t_halt();
        tx_ready = 1'b0;
        setup(0, 6'd16, 3'd3);
        push_tx(16'hF0);
        push_tx(16'hF1);
        push_tx(16'hF2);
        chk("R10 valid with data", tx_valid, 1);
        chk("R10 head data", tx_data, 16'hF0);
        proto_nack = 1'b1; #1;
        chk("R11 valid drops at once", tx_valid, 0);
        tick();
        chk("R11 halted", tx_halted, 1);
        tx_ready = 1'b1;
        tick(); tick();
        chk("R11 nothing sent", tx_level, 3);
        proto_nack = 1'b0;
        tick();
        chk("R11 still halted after clear", tx_halted, 1);
        chk("R11 still silent after clear", tx_valid, 0);
        tx_flush = 1'b1; tick(); tx_flush = 1'b0;
        chk("R11 resumed", tx_halted, 0);
        chk("R9 emptied by flush", tx_level, 0);
        tx_ready = 1'b0;
        push_tx(16'hF9);
        chk("R11 sends again", tx_valid, 1);
        chk("R11 new data", tx_data, 16'hF9);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        chk("R10 accepted", tx_level, 0);
        // error path: flush while fault still high does not resume
        proto_err = 1'b1;
        tick();
        tx_flush = 1'b1; tick(); tx_flush = 1'b0;
        chk("R11 flush during fault", tx_halted, 1);
        proto_err = 1'b0;
        tick();
        push_tx(16'hFA);
        chk("R11 armed stays silent", tx_valid, 0);
        chk("R11 word held", tx_level, 1);
        tx_flush = 1'b1; tick(); tx_flush = 1'b0;
        chk("R11 resumed after err", tx_halted, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_size_map();
        t_disabled();
        t_ptr_ignore();
        t_window();
        t_full_empty();
        t_simul();
        t_flush();
        t_halt();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule